// File: doc/BRIEF.md
# Iterative Shift Unit

This block performs shift and rotate operations one bit position per clock. It works on a single 16-bit word or on a 32-bit pair. A start pulse captures the operand words, seven low bits of the opcode word and the multi-length flag. The block then runs for as many clocks as the requested count. It raises a one-cycle done pulse when the result and the sign/overflow flags are ready.

In single-length mode only the accumulator word is shifted. In double-length mode the accumulator is the upper half of a 32-bit value and the second word is the lower half. Fetching operands from memory and writing results back belong to the surrounding datapath. The carry flag never passes through this block, so it is left untouched.

Top module: `shift_iter`

## Requirements
- R1: After reset, busy and done are 0, both data outputs are 0, and both flag outputs are 0.
- R2: A start sampled while idle captures all inputs. With a count of N, done is high for exactly one cycle after the Nth rising edge that follows the capture edge. A count of 0 raises done right after the capture edge and returns the data unchanged. Busy is high in between, and the outputs hold their values while the block is idle with no start.
- R3: In single-length mode the count is op[3:0] (0..15). In double-length mode the count is op[4:0] (0..31).
- R4: op[6] selects the direction: 0 shifts right and 1 shifts left.
- R5: In single-length mode op[5:4] selects the type: 00 or 01 is arithmetic, 10 is logical, 11 is rotate. Only the accumulator word is shifted, and low_out returns low_in unchanged.
- R6: An arithmetic right shift fills with the original sign bit. A logical right shift fills with 0. Every left shift fills with 0.
- R7: A single-length rotate feeds each bit leaving one end back into the other end.
- R8: In double-length mode, {acc_in, low_in} is shifted as one 32-bit value, with acc_in as the upper half. op[5] = 0 selects arithmetic and op[5] = 1 selects logical.
- R9: After an arithmetic shift, s_out is the final MSB (acc_out[15]). v_out is 1 if any bit that occupied the MSB during the shift differed from the original sign, even when the final sign matches it. An arithmetic right shift therefore always gives v_out = 0.
- R10: After a logical shift or a rotate, s_out and v_out equal the s_in and v_in values captured at start.
- R11: A start that arrives while busy is ignored. The operation already in progress finishes with its own timing and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (only honoured while idle) |
| dbl | input | 1 | Multi-length flag: 1 selects 32-bit double-length mode |
| op | input | 7 | Low opcode bits: [3:0] count, [5:4] type, [6] direction |
| acc_in | input | 16 | Accumulator word (upper half in double mode) |
| low_in | input | 16 | Second word (lower half in double mode) |
| s_in | input | 1 | Current sign flag |
| v_in | input | 1 | Current overflow flag |
| busy | output | 1 | Shift in progress |
| done | output | 1 | One-cycle pulse: results valid |
| acc_out | output | 16 | Shifted upper/single word |
| low_out | output | 16 | Shifted lower word (pass-through in single mode) |
| s_out | output | 1 | Resulting sign flag |
| v_out | output | 1 | Resulting overflow flag |

## Verification
Every result is due on the done pulse. The pulse follows the Nth rising edge after the capture edge, or the capture edge itself when N is 0. The bench counts falling edges from the capture edge until done appears and compares that count with N. It reads acc_out, low_out, s_out and v_out in that same falling-edge window. It never samples in a fixed cycle that would hide a latency error. A start driven in the middle of a run checks that the pending operation keeps both its latency and its result.

// File: rtl/shift_iter.sv
module shift_iter #(
  parameter int HALF_W = 16,
  localparam int SC_W = $clog2(HALF_W),
  localparam int OP_W = SC_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dbl,
  input  logic [OP_W-1:0]   op,
  input  logic [HALF_W-1:0] acc_in,
  input  logic [HALF_W-1:0] low_in,
  input  logic              s_in,
  input  logic              v_in,
  output logic              busy,
  output logic              done,
  output logic [HALF_W-1:0] acc_out,
  output logic [HALF_W-1:0] low_out,
  output logic              s_out,
  output logic              v_out
);
  localparam int FULL_W = 2 * HALF_W;
  localparam int CW = SC_W + 1;

  typedef enum logic [1:0] {K_ARITH, K_LOGIC, K_ROT} kind_t;

  logic [FULL_W-1:0] data_q, step_d, dbl_step;
  logic [HALF_W-1:0] hi, hi_step;
  logic [CW-1:0]     cnt_q, cnt_req;
  logic              busy_q, done_q, dbl_q, left_q, sign0_q, vacc_q, s_q, v_q;
  logic              fill_r, v_next;
  kind_t             kind_q, kind_req;

  assign cnt_req = dbl ? op[SC_W:0] : {1'b0, op[SC_W-1:0]};

  always_comb begin
    if (dbl)
      kind_req = op[SC_W+1] ? K_LOGIC : K_ARITH;
    else if (!op[SC_W+1])
      kind_req = K_ARITH;
    else
      kind_req = op[SC_W] ? K_ROT : K_LOGIC;
  end

  assign hi      = data_q[FULL_W-1:HALF_W];
  assign fill_r  = (kind_q == K_ARITH) ? hi[HALF_W-1] :
                   (kind_q == K_ROT)   ? hi[0]        : 1'b0;
  assign hi_step = left_q ? {hi[HALF_W-2:0], (kind_q == K_ROT) & hi[HALF_W-1]}
                          : {fill_r, hi[HALF_W-1:1]};
  assign dbl_step = left_q ? {data_q[FULL_W-2:0], 1'b0}
                           : {(kind_q == K_ARITH) & data_q[FULL_W-1], data_q[FULL_W-1:1]};
  assign step_d  = dbl_q ? dbl_step : {hi_step, data_q[HALF_W-1:0]};
  assign v_next  = vacc_q | (step_d[FULL_W-1] ^ sign0_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      dbl_q   <= 1'b0;
      left_q  <= 1'b0;
      kind_q  <= K_ARITH;
      sign0_q <= 1'b0;
      vacc_q  <= 1'b0;
      s_q     <= 1'b0;
      v_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        data_q <= step_d;
        cnt_q  <= cnt_q - CW'(1);
        vacc_q <= v_next;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (kind_q == K_ARITH) begin
            s_q <= step_d[FULL_W-1];
            v_q <= v_next;
          end
        end
      end else if (start) begin
        data_q  <= {acc_in, low_in};
        cnt_q   <= cnt_req;
        dbl_q   <= dbl;
        left_q  <= op[SC_W+2];
        kind_q  <= kind_req;
        sign0_q <= acc_in[HALF_W-1];
        vacc_q  <= 1'b0;
        if (kind_req == K_ARITH) begin
          s_q <= acc_in[HALF_W-1];
          v_q <= 1'b0;
        end else begin
          s_q <= s_in;
          v_q <= v_in;
        end
        if (cnt_req == '0) done_q <= 1'b1;
        else               busy_q <= 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign acc_out = data_q[FULL_W-1:HALF_W];
  assign low_out = data_q[HALF_W-1:0];
  assign s_out   = s_q;
  assign v_out   = v_q;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));
  // R11
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (cnt_q == $past(cnt_q) - CW'(1)));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(data_q));
  // R5
  low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !dbl_q) |=> $stable(low_out));
  // R7
  rot_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !dbl_q && kind_q == K_ROT) |=> ($countones(acc_out) == $countones($past(acc_out))));
  // R9
  right_arith_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && kind_q == K_ARITH && !left_q) |-> !v_q);
endmodule

// File: tb/shift_iter_tb_top.sv
`timescale 1ns/1ps
module shift_iter_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, dbl = 1'b0, s_in = 1'b0, v_in = 1'b0;
  logic [6:0]  op = '0;
  logic [15:0] acc_in = '0, low_in = '0;
  logic        busy, done, s_out, v_out;
  logic [15:0] acc_out, low_out;
  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  shift_iter dut_i (.clk(clk), .rst_n(rst_n), .start(start), .dbl(dbl), .op(op),
    .acc_in(acc_in), .low_in(low_in), .s_in(s_in), .v_in(v_in), .busy(busy), .done(done),
    .acc_out(acc_out), .low_out(low_out), .s_out(s_out), .v_out(v_out));

  function automatic logic [33:0] ref_op(logic [15:0] a, logic [15:0] l, logic [6:0] o,
                                         logic d, logic si, logic vi);
    logic [31:0] w = {a, l};
    logic [15:0] h = a;
    logic sign0 = a[15], vs = 1'b0, arith, rot, left;
    int n;
    left = o[6];
    arith = !o[5];
    rot = !d && o[5:4] == 2'b11;
    n = d ? int'(o[4:0]) : int'(o[3:0]);
    for (int i = 0; i < n; i++) begin
      if (d) begin
        if (left) w = {w[30:0], 1'b0};
        else      w = {arith ? w[31] : 1'b0, w[31:1]};
        if (w[31] != sign0) vs = 1'b1;
      end else begin
        if (left) h = {h[14:0], rot ? h[15] : 1'b0};
        else      h = {arith ? h[15] : (rot ? h[0] : 1'b0), h[15:1]};
        if (h[15] != sign0) vs = 1'b1;
      end
    end
    if (!d) w = {h, l};
    if (arith) return {w, w[31], vs};
    return {w, si, vi};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [15:0] a, logic [15:0] l, logic [6:0] o, logic d,
                        logic si, logic vi, string req, bit poke);
    logic [33:0] exp = ref_op(a, l, o, d, si, vi);
    int n = d ? int'(o[4:0]) : int'(o[3:0]);
    int k = 0;
    @(negedge clk);
    acc_in = a; low_in = l; op = o; dbl = d; s_in = si; v_in = vi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && k < 40) begin
      @(negedge clk);
      k++;
      if (poke && k == 2) begin
        acc_in = ~a; low_in = ~l; op = 7'h00; start = 1'b1;
      end else start = 1'b0;
      if (!done && k < n) check(busy === 1'b1, "R2 busy", 64'(busy), 64'd1);
    end
    check(k == n, {req, " R2 latency"}, 64'(k), 64'(n));
    check({acc_out, low_out} === exp[33:2], {req, " data"}, 64'({acc_out, low_out}), 64'(exp[33:2]));
    check({s_out, v_out} === exp[1:0], {req, " flags"}, 64'({s_out, v_out}), 64'(exp[1:0]));
  endtask

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1
    check({busy, done, acc_out, low_out, s_out, v_out} === '0, "R1 reset",
          64'({busy, done, acc_out, low_out, s_out, v_out}), 64'd0);
    rst_n = 1'b1;
    // R2 zero count
    run_op(16'hA5C3, 16'h1234, 7'b1010000, 1'b0, 1'b1, 1'b1, "R2 zero", 0);
    // R6 arithmetic right sign fill, R9 no overflow
    run_op(16'h8001, 16'h0F0F, 7'b0000011, 1'b0, 1'b0, 1'b1, "R6 R9 asr", 0);
    // R6 logical right
    run_op(16'h8001, 16'h0000, 7'b0100011, 1'b0, 1'b1, 1'b0, "R6 R10 lsr", 0);
    // R9 sign passes through and returns: 4000 << 2
    run_op(16'h4000, 16'h0000, 7'b1000010, 1'b0, 1'b0, 1'b0, "R9 sticky", 0);
    // R7 rotate left and right
    run_op(16'h8003, 16'h5555, 7'b1110001, 1'b0, 1'b0, 1'b1, "R7 rol", 0);
    run_op(16'h0001, 16'h5555, 7'b0110100, 1'b0, 1'b1, 1'b0, "R7 ror", 0);
    // R3 R8 double count 31 and count 16
    run_op(16'h0000, 16'h0001, 7'b1011111, 1'b1, 1'b0, 1'b0, "R3 R8 dsll31", 0);
    run_op(16'h8000, 16'h0000, 7'b0010000, 1'b1, 1'b0, 1'b0, "R3 R8 dsra16", 0);
    run_op(16'hF00F, 16'h00FF, 7'b0110100, 1'b1, 1'b1, 1'b1, "R8 R10 dsrl", 0);
    // R4 R5 single max count
    run_op(16'h0001, 16'hBEEF, 7'b1001111, 1'b0, 1'b0, 1'b0, "R4 R5 sla15", 0);
    // R11 start while busy
    run_op(16'h1357, 16'h2468, 7'b1101010, 1'b0, 1'b0, 1'b0, "R11 ignore", 1);
    for (int i = 0; i < 300; i++) begin
      logic [6:0] o = 7'($urandom());
      logic d = 1'($urandom());
      run_op(16'($urandom()), 16'($urandom()), o, d, 1'($urandom()), 1'($urandom()),
             "R3 R4 R5 R6 R7 R8 R9 R10 random", 0);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule